// File: doc/BRIEF.md
# Tri-State Remote Code Encoder

This block produces the serial on/off keying pulse train of a fixed-length remote-control code word. Twelve symbols go out per frame, eight address trits and then four data bits. Each address trit can be zero, one or floating. Every frame ends with a long synchronisation symbol. A clock-enable tick stands in for the encoder oscillator, and every pulse width is counted in those ticks. The single output line drives an external OOK/ASK transmitter.

A caller sets the address, the data and a repeat count, then strobes start. The block captures the word and sends it as back-to-back frames. A code-symbol width is 16 ticks per pair and 32 ticks per symbol. The repeat count is clamped to a minimum, because a receiver commonly misses the first synchronisation symbol of a burst. A busy flag covers the whole burst. A start request that carries an invalid trit is refused and raises an error flag.

Top module: `tri_code_encoder`

## Requirements
- R1: While rst_ni is low, and at the first idle cycles after it, tx_o, busy_o and err_o are all 0.
- R2: A start_i seen at a clock edge while busy_o is 0 and all trits are valid captures addr_i, data_i and repeat_i and sets busy_o from the next cycle. err_o is 0 from that same cycle.
- R3: The line changes level only on a cycle with tick_i high. Each code symbol lasts 32 ticks, made of two high-then-low pairs of 16 ticks. A short level is 4 ticks and a long level is 12 ticks.
- R4: Trit code 2'b00 (zero) sends short-high/long-low twice. Code 2'b11 (one) sends long-high/short-low twice. Code 2'b01 (floating) sends short-high/long-low and then long-high/short-low.
- R5: Symbol order within a frame is address trit 0 up to trit 7, where trit i is addr_i[2i+1:2i]. Data bit 0 up to bit 3 follows, where bit i is data_i[2i+1:2i]. The sync symbol comes last.
- R6: The sync symbol is 4 ticks high followed by 124 ticks low, which is 128 ticks in total.
- R7: The number of frames sent is repeat_i, or 4 when repeat_i is below 4. Frames follow each other with no gap, so a burst lasts 512 ticks per frame.
- R8: A start_i while idle that has a data code other than 2'b00/2'b11, or an address code of 2'b10, sets err_o and does not start. busy_o and tx_o stay 0. err_o keeps its value until the next start_i seen while idle.
- R9: start_i while busy_o is 1 has no effect on the waveform, the burst length or err_o.
- R10: busy_o falls in the cycle after the tick that ends the last sync symbol. tx_o is 0 whenever busy_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oscillator-tick clock enable |
| start_i | input | 1 | Start request |
| addr_i | input | 16 | Eight address trits, 2 bits each |
| data_i | input | 8 | Four data bits, 2-bit trit code each |
| repeat_i | input | 4 | Requested frame count |
| tx_o | output | 1 | Serial keyed output line |
| busy_o | output | 1 | Burst in progress |
| err_o | output | 1 | Last idle start request was rejected |

## Verification
The bench builds the block with its default parameters: 8 address trits, 4 data bits, 4/12-tick short/long widths, a 128-tick sync and a 4-bit repeat count with a minimum of 4. With these values a full burst is between 2048 and 7680 ticks long, so the clamp from repeat values 0 to 3 up to 4 frames can be reached, and so can the largest count of 15. The tick is driven every cycle in some runs and sparsely in others, so that stalled ticks are seen to freeze the line. Floating trits are placed in every address slot, and a start request is injected in the middle of a burst.

// File: rtl/tce_pkg.sv
package tce_pkg;
  typedef logic [1:0] trit_t;
  localparam trit_t TRIT_ZERO  = 2'b00;
  localparam trit_t TRIT_ONE   = 2'b11;
  localparam trit_t TRIT_FLOAT = 2'b01;
  localparam trit_t TRIT_BAD   = 2'b10;
endpackage

// File: rtl/tce_validator.sv
module tce_validator
  import tce_pkg::*;
#(
  parameter int N_ADDR = 8,
  parameter int N_DATA = 4
) (
  input  logic [2*N_ADDR-1:0] addr_i,
  input  logic [2*N_DATA-1:0] data_i,
  output logic                bad_o
);
  logic [N_ADDR-1:0] addr_bad;
  logic [N_DATA-1:0] data_bad;

  for (genvar i = 0; i < N_ADDR; i++) begin : g_addr
    assign addr_bad[i] = (addr_i[2*i +: 2] == TRIT_BAD);
  end
  // data positions may not float
  for (genvar i = 0; i < N_DATA; i++) begin : g_data
    assign data_bad[i] = (data_i[2*i+1] != data_i[2*i]);
  end

  assign bad_o = (|addr_bad) | (|data_bad);
endmodule

// File: rtl/tce_level_timer.sv
module tce_level_timer #(
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  assign done_o = tick_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/tce_symbol_seq.sv
module tce_symbol_seq
  import tce_pkg::*;
#(
  parameter int N_ADDR     = 8,
  parameter int N_DATA     = 4,
  parameter int SHORT_T    = 4,
  parameter int LONG_T     = 12,
  parameter int SYNC_LOW_T = 124,
  parameter int REP_W      = 4,
  parameter int MIN_REP    = 4,
  parameter int CNT_W      = 7
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                accept_i,
  input  logic [2*N_ADDR-1:0] addr_i,
  input  logic [2*N_DATA-1:0] data_i,
  input  logic [REP_W-1:0]    repeat_i,
  input  logic                lvl_done_i,
  output logic                busy_o,
  output logic                tx_o,
  output logic                load_o,
  output logic [CNT_W-1:0]    load_val_o
);
  localparam int N_SYM = N_ADDR + N_DATA;
  localparam int SYM_W = $clog2(N_SYM + 1);
  localparam logic [SYM_W-1:0] SYNC_IDX = SYM_W'(N_SYM);

  logic             busy_q;
  logic [SYM_W-1:0] sym_q, nxt_sym;
  logic [1:0]       lvl_q, nxt_lvl;
  logic [REP_W-1:0] frames_q, n_frames;
  trit_t            codes_q [N_SYM];
  trit_t            nxt_code;
  logic             frame_end, nxt_bit;
  int               width;

  assign n_frames = (repeat_i < REP_W'(MIN_REP)) ? REP_W'(MIN_REP) : repeat_i;

  always_comb begin
    nxt_sym   = sym_q;
    nxt_lvl   = lvl_q + 2'd1;
    frame_end = 1'b0;
    if (accept_i) begin
      nxt_sym = '0;
      nxt_lvl = '0;
    end else if (sym_q == SYNC_IDX) begin
      if (lvl_q[0]) begin
        frame_end = 1'b1;
        nxt_sym   = '0;
        nxt_lvl   = '0;
      end
    end else if (lvl_q == 2'd3) begin
      nxt_sym = sym_q + 1'b1;
      nxt_lvl = '0;
    end
  end

  always_comb begin
    if (accept_i)                   nxt_code = trit_t'(addr_i[1:0]);
    else if (nxt_sym >= SYNC_IDX)   nxt_code = TRIT_ZERO;
    else                            nxt_code = codes_q[nxt_sym];
    // first pair keyed by code[1], second by code[0]
    nxt_bit = nxt_lvl[1] ? nxt_code[0] : nxt_code[1];
    if (!accept_i && nxt_sym == SYNC_IDX)
      width = nxt_lvl[0] ? SYNC_LOW_T : SHORT_T;
    else
      width = (nxt_bit == !nxt_lvl[0]) ? LONG_T : SHORT_T;
  end

  assign load_o     = accept_i || (busy_q && lvl_done_i);
  assign load_val_o = CNT_W'(width - 1);
  assign busy_o     = busy_q;
  assign tx_o       = busy_q && !lvl_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      sym_q    <= '0;
      lvl_q    <= '0;
      frames_q <= '0;
    end else if (accept_i) begin
      busy_q   <= 1'b1;
      sym_q    <= nxt_sym;
      lvl_q    <= nxt_lvl;
      frames_q <= n_frames;
    end else if (busy_q && lvl_done_i) begin
      if (frame_end) begin
        if (frames_q == REP_W'(1)) busy_q <= 1'b0;
        frames_q <= frames_q - 1'b1;
      end
      sym_q <= nxt_sym;
      lvl_q <= nxt_lvl;
    end
  end

  for (genvar i = 0; i < N_SYM; i++) begin : g_cap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        codes_q[i] <= TRIT_ZERO;
      else if (accept_i) begin
        if (i < N_ADDR)   codes_q[i] <= trit_t'(addr_i[2*i +: 2]);
        else              codes_q[i] <= trit_t'(data_i[2*(i-N_ADDR) +: 2]);
      end
    end
  end
endmodule

// File: rtl/tri_code_encoder.sv
module tri_code_encoder #(
  parameter int N_ADDR  = 8,
  parameter int N_DATA  = 4,
  parameter int SHORT_T = 4,
  parameter int LONG_T  = 12,
  parameter int SYNC_T  = 128,
  parameter int REP_W   = 4,
  parameter int MIN_REP = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                start_i,
  input  logic [2*N_ADDR-1:0] addr_i,
  input  logic [2*N_DATA-1:0] data_i,
  input  logic [REP_W-1:0]    repeat_i,
  output logic                tx_o,
  output logic                busy_o,
  output logic                err_o
);
  localparam int SYNC_LOW_T = SYNC_T - SHORT_T;
  localparam int MAX_T      = (SYNC_LOW_T > LONG_T) ? SYNC_LOW_T : LONG_T;
  localparam int CNT_W      = $clog2(MAX_T) < 1 ? 1 : $clog2(MAX_T);

  logic             bad, accept, lvl_done, load, busy, err_q;
  logic [CNT_W-1:0] load_val;

  tce_validator #(.N_ADDR(N_ADDR), .N_DATA(N_DATA)) i_val (
    .addr_i(addr_i), .data_i(data_i), .bad_o(bad)
  );

  assign accept = start_i && !busy && !bad;

  tce_level_timer #(.CNT_W(CNT_W)) i_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .load_i(load), .load_val_i(load_val), .done_o(lvl_done)
  );

  tce_symbol_seq #(
    .N_ADDR(N_ADDR), .N_DATA(N_DATA), .SHORT_T(SHORT_T), .LONG_T(LONG_T),
    .SYNC_LOW_T(SYNC_LOW_T), .REP_W(REP_W), .MIN_REP(MIN_REP), .CNT_W(CNT_W)
  ) i_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .accept_i(accept),
    .addr_i(addr_i), .data_i(data_i), .repeat_i(repeat_i),
    .lvl_done_i(lvl_done), .busy_o(busy), .tx_o(tx_o),
    .load_o(load), .load_val_o(load_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                err_q <= 1'b0;
    else if (start_i && !busy)  err_q <= bad;
  end

  assign busy_o = busy;
  assign err_o  = err_q;
endmodule

// File: rtl/tce_checker.sv
module tce_checker #(
  parameter int N_ADDR  = 8,
  parameter int N_DATA  = 4,
  parameter int SHORT_T = 4,
  parameter int LONG_T  = 12,
  parameter int SYNC_T  = 128,
  parameter int REP_W   = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                tick_i,
  input logic                start_i,
  input logic [2*N_ADDR-1:0] addr_i,
  input logic [2*N_DATA-1:0] data_i,
  input logic [REP_W-1:0]    repeat_i,
  input logic                tx_o,
  input logic                busy_o,
  input logic                err_o
);
  logic       req_ok;
  logic [7:0] hi_run, lo_run;

  always_comb begin
    req_ok = 1'b1;
    for (int i = 0; i < N_ADDR; i++) if (addr_i[2*i +: 2] == 2'b10) req_ok = 1'b0;
    for (int i = 0; i < N_DATA; i++) if (data_i[2*i] != data_i[2*i+1]) req_ok = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_run <= '0;
      lo_run <= '0;
    end else if (!busy_o) begin
      hi_run <= '0;
      lo_run <= '0;
    end else if (tick_i) begin
      hi_run <= tx_o ? hi_run + 1'b1 : '0;
      lo_run <= tx_o ? '0 : lo_run + 1'b1;
    end else begin
      if (!tx_o) hi_run <= '0;
      if (tx_o)  lo_run <= '0;
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk_i) !rst_ni |-> (!tx_o && !busy_o && !err_o));
  p_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && req_ok) |=> (busy_o && !err_o));
  p_no_tick_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_i) |=> (busy_o && $stable(tx_o)));
  p_high_max_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && tx_o) |-> (hi_run < 8'(LONG_T)));
  p_low_max_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tx_o) |-> (lo_run < 8'(SYNC_T - SHORT_T)));
  p_reject_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !req_ok) |=> (err_o && !busy_o));
  p_err_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni) err_o |-> !busy_o);
  p_busy_err_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(err_o));
  p_idle_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni) !busy_o |-> !tx_o);
endmodule

bind tri_code_encoder tce_checker #(
  .N_ADDR(N_ADDR), .N_DATA(N_DATA), .SHORT_T(SHORT_T), .LONG_T(LONG_T),
  .SYNC_T(SYNC_T), .REP_W(REP_W)
) i_tce_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .start_i(start_i),
  .addr_i(addr_i), .data_i(data_i), .repeat_i(repeat_i),
  .tx_o(tx_o), .busy_o(busy_o), .err_o(err_o)
);

// File: tb/test_tri_code_encoder.sv
module test_tri_code_encoder;
  localparam int FRAME_T = 512;
  localparam int CODE_T  = 384;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  data_i = '0;
  logic [3:0]  repeat_i = '0;
  logic        tx_o, busy_o, err_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #10 clk_i = ~clk_i;

  tri_code_encoder i_tri_code_encoder (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .start_i(start_i),
    .addr_i(addr_i), .data_i(data_i), .repeat_i(repeat_i),
    .tx_o(tx_o), .busy_o(busy_o), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expected line level at tick j of a burst (R3, R4, R5, R6)
  function automatic bit exp_level(input logic [15:0] a, input logic [7:0] d, input int j);
    int pos, s, o, w;
    logic [1:0] code;
    bit b;
    pos = j % FRAME_T;
    if (pos >= CODE_T) return (pos - CODE_T) < 4;
    s = pos / 32;
    code = (s < 8) ? a[2*s +: 2] : d[2*(s-8) +: 2];
    o = pos % 32;
    b = (o < 16) ? code[1] : code[0];
    w = b ? 12 : 4;
    return (o % 16) < w;
  endfunction

  function automatic logic [15:0] rand_addr();
    logic [15:0] a;
    for (int i = 0; i < 8; i++) begin
      case ($urandom % 3)
        0: a[2*i +: 2] = 2'b00;
        1: a[2*i +: 2] = 2'b11;
        default: a[2*i +: 2] = 2'b01;
      endcase
    end
    return a;
  endfunction

  function automatic logic [7:0] rand_data();
    logic [7:0] d;
    for (int i = 0; i < 4; i++) d[2*i +: 2] = ($urandom % 2) ? 2'b11 : 2'b00;
    return d;
  endfunction

  task automatic run_tx(input logic [15:0] a, input logic [7:0] d, input logic [3:0] r,
                        input int tick_pct, input bit inject, input string code_tag);
    int frames, j, mis_code, mis_sync, first_j;
    bit injected, act;
    frames = (r < 4) ? 4 : int'(r);
    j = 0; mis_code = 0; mis_sync = 0; first_j = -1; injected = 0;
    @(negedge clk_i);
    addr_i = a; data_i = d; repeat_i = r; start_i = 1'b1;
    tick_i = (($urandom % 100) < tick_pct);
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R2", "busy after start", busy_o, 1);
    chk(err_o == 1'b0, "R2", "err after valid start", err_o, 0);
    while (busy_o) begin
      tick_i = (($urandom % 100) < tick_pct);
      if (inject && !injected && j >= 100) begin
        start_i = 1'b1; addr_i = ~a; data_i = 8'h01; repeat_i = 4'd15; injected = 1'b1;
      end else start_i = 1'b0;
      if (tick_i) begin
        act = tx_o;
        if (act != exp_level(a, d, j)) begin
          if ((j % FRAME_T) >= CODE_T) mis_sync++; else mis_code++;
          if (first_j < 0) first_j = j;
        end
        j++;
      end
      @(negedge clk_i);
    end
    start_i = 1'b0;
    if (first_j >= 0) $display("  first level mismatch at tick %0d", first_j);
    chk(mis_code == 0, code_tag, "code-symbol tick mismatches", mis_code, 0);
    chk(mis_sync == 0, "R6", "sync tick mismatches", mis_sync, 0);
    chk(j == frames * FRAME_T, "R7", "burst length in ticks", j, frames * FRAME_T);
    chk(tx_o == 1'b0, "R10", "line low after burst", tx_o, 0);
    if (inject) begin
      chk(mis_code + mis_sync == 0 && j == frames * FRAME_T, "R9",
          "burst unchanged by start while busy", j, frames * FRAME_T);
      chk(err_o == 1'b0, "R9", "err unchanged by start while busy", err_o, 0);
    end
  endtask

  task automatic run_reject(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; data_i = d; repeat_i = 4'd4; start_i = 1'b1; tick_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(err_o == 1'b1, "R8", "err after invalid start", err_o, 1);
    chk(busy_o == 1'b0, "R8", "busy after invalid start", busy_o, 0);
    repeat (5) @(negedge clk_i);
    chk(busy_o == 1'b0 && tx_o == 1'b0, "R8", "still idle after reject", {busy_o, tx_o}, 0);
    chk(err_o == 1'b1, "R8", "err held while idle", err_o, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!finished) begin
      n_fail++;
      $display("FAIL R10 watchdog: actual busy %0d expected burst end", busy_o);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    chk({tx_o, busy_o, err_o} == 3'b000, "R1", "outputs in reset", {tx_o, busy_o, err_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk({tx_o, busy_o, err_o} == 3'b000, "R1", "outputs after reset", {tx_o, busy_o, err_o}, 0);

    // all zero, repeat clamped to minimum
    run_tx(16'h0000, 8'h00, 4'd0, 100, 1'b0, "R4");
    // all floating address, all-one data, above minimum
    run_tx(16'h5555, 8'hFF, 4'd9, 100, 1'b0, "R4");
    // distinct trit per slot to expose ordering
    run_tx(16'b01_11_00_01_11_00_11_01, 8'b11_00_00_11, 4'd3, 100, 1'b0, "R5");
    // sparse ticks must stall the line
    run_tx(rand_addr(), rand_data(), 4'd4, 30, 1'b0, "R3");
    // start while busy
    run_tx(rand_addr(), rand_data(), 4'd4, 100, 1'b1, "R4");
    // rejects: floating data, bad address code
    run_reject(16'h0000, 8'b00_01_00_00);
    run_reject(16'b00_00_10_00_00_00_00_00, 8'h00);
    run_tx(rand_addr(), rand_data(), 4'd1, 100, 1'b0, "R4");
    for (int k = 0; k < 6; k++)
      run_tx(rand_addr(), rand_data(), 4'($urandom % 8), 40 + int'($urandom % 60), 1'b0, "R4");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule